// File: doc/BRIEF.md
# Transmit Completion Status Ring Writer

The block turns transmit-completion events into 128-bit status records and stores them, one record per accepted event, in a circular ring held in on-chip memory. Each event brings the descriptor count, ring ID, status code, transmit timestamp, MCS, channel-bonding mode, QID, MSDU count, retry flag, antenna sector and sequence number. The block packs these fields into four 32-bit words and writes the record at the head slot. It then moves the head forward, wrapping from the last slot back to slot 0, and raises a one-cycle interrupt-request pulse.

Bit 31 of word 0 is a ready flag. Its written value comes from a phase register that inverts on every wrap. A consumer walking the ring therefore tells new records from stale ones without ever reading a head pointer. The consumer reports its progress through a tail register. The block refuses events while the head is one slot behind the tail. Records are read back through a registered read port.

Top module: `tcs_ring_writer`

## Requirements
- R1: The ring memory holds all zeros at power-up. After reset, `evt_ready` is 1 and both `irq_pulse` and `reject_pulse` are 0.
- R2: Word 0 (record bits 31:0) carries the descriptor count in bits 7:0, the ring ID in bits 15:8 and the status code in bits 23:16. Bits 30:24 are 0.
- R3: Word 1 (record bits 63:32) is the 32-bit timestamp, copied without change.
- R4: Word 2 (record bits 95:64) places the fields as follows, with every other bit 0:
  - MCS in bits 4:0
  - CB mode in bits 7:6 (0 DMG, 1 EDMG, 2 wide)
  - QID in bits 12:8
  - MSDU count in bits 20:16
  - retry in bit 23
  - sector in bits 31:24
- R5: Word 3 (record bits 127:96) holds the 12-bit sequence number in bits 11:0. Its bits 31:12 are 0.
- R6: Record bit 31 is written as 1 during the first pass through the ring after reset. The value written inverts each time the head wraps from slot 2^ORDER-1 to slot 0.
- R7: The n-th written record after reset lands in slot n mod 2^ORDER, counting from n = 0. The ring holds 2^ORDER slots, and ORDER defaults to 12.
- R8: The ring is full when head+1 equals the tail, modulo the ring size. While it is full, `evt_ready` is 0, and an offered event writes no slot and raises no interrupt.
- R9: An accepted event whose status code is 4 to 255 is rejected. It writes nothing, does not move the head, raises no interrupt, and pulses `reject_pulse` for one cycle in the next cycle.
- R10: Each written record pulses `irq_pulse` high for exactly one cycle, in the cycle after the write.
- R11: A write to the tail register takes effect at the next clock edge and frees the slots up to the new tail.
- R12: A synchronous reset returns the head and the tail to slot 0 and sets the phase to 1, even after the ring has wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | A completion event is offered |
| evt_ready | output | 1 | The event is taken at this edge (ring not full) |
| evt_desc_cnt | input | 8 | Number of descriptors |
| evt_ring_id | input | 8 | Transmit ring ID |
| evt_code | input | 8 | Status code: 0 ok, 1 retry limit, 2 lifetime, 3 released |
| evt_tstamp | input | 32 | Transmit timestamp |
| evt_mcs | input | 5 | MCS used |
| evt_cb_mode | input | 2 | Channel-bonding mode |
| evt_qid | input | 5 | Queue ID |
| evt_msdu_cnt | input | 5 | MSDUs in the aggregate |
| evt_retry | input | 1 | Transmission was retried |
| evt_sector | input | 8 | Antenna sector |
| evt_seq | input | 12 | Sequence number |
| tail_wr | input | 1 | Load the tail register |
| tail_val | input | ORDER | New tail slot |
| rd_addr | input | ORDER | Slot to read |
| rd_data | output | 128 | Record at `rd_addr`, one cycle later |
| irq_pulse | output | 1 | One-cycle pulse per written record |
| reject_pulse | output | 1 | One-cycle pulse per rejected event |

## Verification
The assertions check the following on every cycle:
- a non-ready cycle is never followed by an interrupt;
- no record with a reserved status code, or with nonzero upper bits in word 3, reaches the memory write port;
- an interrupt always comes with a moved head;
- the phase only changes on a return to slot 0;
- a rejection and an interrupt are never raised together.

The remaining behaviour can only be shown by the bench's scenarios:
- the exact placement of every field;
- slot order across two wraps, with the ready bit inverting and then restoring;
- slots that stay untouched while the ring is full;
- recovery after a tail update or a reset in mid-run.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int REC_W     = 128;
  localparam int CODE_W    = 8;
  localparam logic [CODE_W-1:0] CODE_LAST = 8'd3;

  typedef struct packed {
    logic [7:0]  desc_cnt;
    logic [7:0]  ring_id;
    logic [7:0]  code;
    logic [31:0] tstamp;
    logic [4:0]  mcs;
    logic [1:0]  cb_mode;
    logic [4:0]  qid;
    logic [4:0]  msdu_cnt;
    logic        retry;
    logic [7:0]  sector;
    logic [11:0] seq;
  } tcs_event_t;

endpackage

// File: rtl/tcs_packer.sv
module tcs_packer
  import tcs_pkg::*;
(
  input  tcs_event_t        evt,
  input  logic              phase,
  output logic [REC_W-1:0]  rec,
  output logic              code_ok
);

  logic [31:0] w0, w1, w2, w3;

  always_comb begin
    w0 = {phase, 7'd0, evt.code, evt.ring_id, evt.desc_cnt};
    w1 = evt.tstamp;
    w2 = {evt.sector, evt.retry, 2'd0, evt.msdu_cnt, 3'd0, evt.qid,
          evt.cb_mode, 1'b0, evt.mcs};
    w3 = {20'd0, evt.seq};
    rec = {w3, w2, w1, w0};
    code_ok = (evt.code <= CODE_LAST);
  end

endmodule

// File: rtl/tcs_ring_ptr.sv
module tcs_ring_ptr #(
  parameter int ORDER = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             tail_wr,
  input  logic [ORDER-1:0] tail_val,
  output logic [ORDER-1:0] head,
  output logic             phase,
  output logic             full
);

  logic [ORDER-1:0] tail;
  logic [ORDER-1:0] head_nxt;

  assign head_nxt = head + ORDER'(1);
  assign full     = (head_nxt == tail);

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      phase <= 1'b1;
    end else begin
      if (adv) begin
        head <= head_nxt;
        if (head_nxt == '0) phase <= ~phase;
      end
      if (tail_wr) tail <= tail_val;
    end
  end

  AST_PHASE_FLIP_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase) |-> (head == '0)); // R6

endmodule

// File: rtl/tcs_ring_mem.sv
module tcs_ring_mem #(
  parameter int ORDER = 12,
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ORDER-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [ORDER-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);

  localparam int DEPTH = 1 << ORDER;

  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tcs_ring_writer.sv
module tcs_ring_writer
  import tcs_pkg::*;
#(
  parameter int ORDER = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [7:0]       evt_desc_cnt,
  input  logic [7:0]       evt_ring_id,
  input  logic [7:0]       evt_code,
  input  logic [31:0]      evt_tstamp,
  input  logic [4:0]       evt_mcs,
  input  logic [1:0]       evt_cb_mode,
  input  logic [4:0]       evt_qid,
  input  logic [4:0]       evt_msdu_cnt,
  input  logic             evt_retry,
  input  logic [7:0]       evt_sector,
  input  logic [11:0]      evt_seq,
  input  logic             tail_wr,
  input  logic [ORDER-1:0] tail_val,
  input  logic [ORDER-1:0] rd_addr,
  output logic [REC_W-1:0] rd_data,
  output logic             irq_pulse,
  output logic             reject_pulse
);

  tcs_event_t       evt;
  logic [REC_W-1:0] rec;
  logic             code_ok;
  logic [ORDER-1:0] head;
  logic             phase;
  logic             full;
  logic             accept;
  logic             mem_we;
  logic             drop;

  assign evt = '{desc_cnt: evt_desc_cnt, ring_id: evt_ring_id, code: evt_code,
                 tstamp: evt_tstamp, mcs: evt_mcs, cb_mode: evt_cb_mode,
                 qid: evt_qid, msdu_cnt: evt_msdu_cnt, retry: evt_retry,
                 sector: evt_sector, seq: evt_seq};

  assign evt_ready = !full;
  assign accept    = evt_valid && !full;
  assign mem_we    = accept && code_ok;
  assign drop      = accept && !code_ok;

  tcs_packer u_pack (
    .evt     (evt),
    .phase   (phase),
    .rec     (rec),
    .code_ok (code_ok)
  );

  tcs_ring_ptr #(.ORDER(ORDER)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .adv      (mem_we),
    .tail_wr  (tail_wr),
    .tail_val (tail_val),
    .head     (head),
    .phase    (phase),
    .full     (full)
  );

  tcs_ring_mem #(.ORDER(ORDER), .WIDTH(REC_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (head),
    .wdata (rec),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse    <= 1'b0;
      reject_pulse <= 1'b0;
    end else begin
      irq_pulse    <= mem_we;
      reject_pulse <= drop;
    end
  end

  AST_FULL_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    !evt_ready |=> !irq_pulse); // R8
  AST_RESERVED_NOT_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (rec[23:16] <= CODE_LAST)); // R9
  AST_DW3_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (rec[127:108] == '0)); // R5
  AST_IRQ_MOVES_HEAD: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (head != $past(head))); // R7
  AST_REJECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    reject_pulse |-> !irq_pulse); // R9

endmodule

// File: tb/tb_tcs_ring_writer.sv
module tb_tcs_ring_writer;

  localparam int ORDER = 3;
  localparam int SIZE  = 1 << ORDER;

  logic clk = 0;
  logic rst = 1;
  logic evt_valid = 0;
  logic evt_ready;
  logic [7:0] evt_desc_cnt = 0, evt_ring_id = 0, evt_code = 0, evt_sector = 0;
  logic [31:0] evt_tstamp = 0;
  logic [4:0] evt_mcs = 0, evt_qid = 0, evt_msdu_cnt = 0;
  logic [1:0] evt_cb_mode = 0;
  logic evt_retry = 0;
  logic [11:0] evt_seq = 0;
  logic tail_wr = 0;
  logic [ORDER-1:0] tail_val = 0;
  logic [ORDER-1:0] rd_addr, mon_addr = 0, dir_addr = 0;
  logic use_dir = 0;
  logic [127:0] rd_data;
  logic irq_pulse, reject_pulse;

  assign rd_addr = use_dir ? dir_addr : mon_addr;

  always #4 clk = ~clk;

  tcs_ring_writer #(.ORDER(ORDER)) dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_desc_cnt(evt_desc_cnt), .evt_ring_id(evt_ring_id), .evt_code(evt_code),
    .evt_tstamp(evt_tstamp), .evt_mcs(evt_mcs), .evt_cb_mode(evt_cb_mode),
    .evt_qid(evt_qid), .evt_msdu_cnt(evt_msdu_cnt), .evt_retry(evt_retry),
    .evt_sector(evt_sector), .evt_seq(evt_seq), .tail_wr(tail_wr),
    .tail_val(tail_val), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_pulse(irq_pulse), .reject_pulse(reject_pulse)
  );

  typedef struct {
    int           slot;
    logic [127:0] rec;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int m_head = 0;
  int m_tail = 0;
  logic m_phase = 1'b1;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [127:0] build(input logic ph, input logic [7:0] dc, rid, st,
      input logic [31:0] ts, input logic [4:0] mcs, input logic [1:0] cb,
      input logic [4:0] qid, msdu, input logic rt, input logic [7:0] sec,
      input logic [11:0] seq);
    logic [31:0] d0, d2, d3;
    d0 = 32'd0;
    d0[31] = ph;
    d0[23:16] = st;
    d0[15:8] = rid;
    d0[7:0] = dc;
    d2 = 32'd0;
    d2[31:24] = sec;
    d2[23] = rt;
    d2[20:16] = msdu;
    d2[12:8] = qid;
    d2[7:6] = cb;
    d2[4:0] = mcs;
    d3 = {20'd0, seq};
    return {d3, d2, ts, d0};
  endfunction

  task automatic send(input logic [7:0] dc, rid, st, input logic [31:0] ts,
      input logic [4:0] mcs, input logic [1:0] cb, input logic [4:0] qid, msdu,
      input logic rt, input logic [7:0] sec, input logic [11:0] seq);
    bit mfull;
    exp_t it;
    mfull = (((m_head + 1) % SIZE) == m_tail);
    evt_desc_cnt = dc; evt_ring_id = rid; evt_code = st; evt_tstamp = ts;
    evt_mcs = mcs; evt_cb_mode = cb; evt_qid = qid; evt_msdu_cnt = msdu;
    evt_retry = rt; evt_sector = sec; evt_seq = seq;
    evt_valid = 1;
    check(evt_ready == !mfull, "R8 ready vs full", 128'(evt_ready), 128'(!mfull));
    if (!mfull && st <= 8'd3) begin
      it.slot = m_head;
      it.rec = build(m_phase, dc, rid, st, ts, mcs, cb, qid, msdu, rt, sec, seq);
      exp_q.push_back(it);
    end
    @(negedge clk);
    evt_valid = 0;
    if (mfull) begin
      check(irq_pulse == 0, "R8 no irq when full", 128'(irq_pulse), 128'(0));
    end else if (st > 8'd3) begin
      check(reject_pulse == 1, "R9 reject pulse", 128'(reject_pulse), 128'(1));
      check(irq_pulse == 0, "R9 no irq on reject", 128'(irq_pulse), 128'(0));
    end else begin
      check(irq_pulse == 1, "R10 irq after write", 128'(irq_pulse), 128'(1));
      m_head = (m_head + 1) % SIZE;
      if (m_head == 0) m_phase = ~m_phase;
    end
    @(negedge clk);
    check(irq_pulse == 0 && reject_pulse == 0, "R10 single-cycle pulses",
          128'({irq_pulse, reject_pulse}), 128'(0));
    repeat (2) @(negedge clk);
  endtask

  task automatic basic(input int k);
    send(8'(k + 1), 8'(k * 3), 8'(k % 4), 32'h1000_0000 + 32'(k * 17),
         5'(k), 2'(k % 3), 5'(k + 2), 5'(k + 1), k[0], 8'(k * 9), 12'(k * 101));
  endtask

  task automatic set_tail(input int v);
    tail_val = ORDER'(v);
    tail_wr = 1;
    @(negedge clk);
    tail_wr = 0;
    m_tail = v;
  endtask

  task automatic read_slot(input int s, output logic [127:0] d);
    use_dir = 1;
    dir_addr = ORDER'(s);
    @(negedge clk);
    d = rd_data;
    use_dir = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    evt_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_head = 0;
    m_tail = 0;
    m_phase = 1'b1;
    @(negedge clk);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(negedge clk);
      if (irq_pulse === 1'b1) begin
        if (exp_q.size() == 0) begin
          check(0, "R10 unexpected irq", 128'(1), 128'(0));
        end else begin
          it = exp_q.pop_front();
          mon_addr = ORDER'(it.slot);
          @(negedge clk);
          check(rd_data === it.rec, $sformatf("R7 record in slot %0d", it.slot),
                rd_data, it.rec);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] d;
    @(negedge clk);
    do_reset();
    check(evt_ready == 1, "R1 ready after reset", 128'(evt_ready), 128'(1));
    check(irq_pulse == 0 && reject_pulse == 0, "R1 pulses low after reset",
          128'({irq_pulse, reject_pulse}), 128'(0));
    read_slot(5, d);
    check(d == '0, "R1 power-up slot zero", d, 128'(0));

    // R2 R3 R4: codes 0..2 with varied fields
    basic(0); basic(1); basic(2);
    // R9: reserved codes, boundary 4 and top 255
    send(8'h11, 8'h22, 8'd4, 32'hDEAD_BEEF, 5'd1, 2'd1, 5'd1, 5'd1, 1'b1, 8'h5A, 12'h123);
    send(8'h33, 8'h44, 8'd255, 32'hCAFE_F00D, 5'd2, 2'd2, 5'd2, 5'd2, 1'b0, 8'hA5, 12'h456);
    // code 3 lands in slot 3 (head unmoved by rejects)
    send(8'hFE, 8'h01, 8'd3, 32'h0BAD_CAFE, 5'd9, 2'd0, 5'd7, 5'd3, 1'b0, 8'h10, 12'h001);
    // R4 R5: all-ones field values
    send(8'hFF, 8'hFF, 8'd0, 32'hFFFF_FFFF, 5'h1F, 2'd3, 5'h1F, 5'h1F, 1'b1, 8'hFF, 12'hFFF);
    basic(5); basic(6);
    // R8: head 7, tail 0 -> full
    send(8'h77, 8'h77, 8'd0, 32'h7, 5'd7, 2'd1, 5'd7, 5'd7, 1'b1, 8'h77, 12'h777);
    read_slot(7, d);
    check(d == '0, "R8 full slot untouched", d, 128'(0));

    // R11: free slots 7,0,1,2 ; R6 phase flips after wrap
    set_tail(4);
    @(negedge clk);
    check(evt_ready == 1, "R11 ready after tail move", 128'(evt_ready), 128'(1));
    basic(7); basic(8); basic(9); basic(10);
    basic(11); // full at head 3
    set_tail(0);
    basic(12); basic(13); basic(14); basic(15);
    basic(16); // full at head 7
    set_tail(2);
    basic(17); basic(18); // slot 7 phase 0, slot 0 phase 1 again (R6)
    basic(19); // full at head 1

    // R12: reset mid-run
    do_reset();
    check(evt_ready == 1, "R12 ready after mid-run reset", 128'(evt_ready), 128'(1));
    basic(20); basic(21);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 scoreboard drained", 128'(exp_q.size()), 128'(0));
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule